// File: doc/BRIEF.md
# Peripheral Address Window Decoder

This block is the address-claiming front end of a loadable memory-mapped peripheral. It keeps a small table of address windows. Each window has a fixed power-of-two size, chosen when the block is built and readable by software for discovery. Each window also has a start address that software writes and a live flag. Software first reads the sizes. It then picks a free range for each window and writes its start address there. A start address that does not sit on a multiple of its window size is refused, and the window stays off.

The decoder watches every bus request, but only while the slot's bus enable is high. It reports a hit when the address falls inside a live window. With the hit it gives the window number and the byte offset into that window. When windows overlap, the lowest-numbered one wins. One cycle after a request that hit, it raises an acknowledge so the peripheral can finish the access. Window 0 is the control region. The default build has a 32-byte control window, a 64 KiB data window and two more windows of 256 bytes and 4 KiB.

Top module: `periph_window_decoder`

## Requirements
- R1: After reset every window is off, every start address reads 0, and no hit or acknowledge is raised.
- R2: Register field 0 of a window (cfg_addr[1:0]=0) reads the window size in bytes, 2 to the power of the build-time log2 size. Writes to this field have no effect.
- R3: A write to field 1 (start address) stores the value. If the value is a multiple of the window size, the window turns on.
- R4: A write to field 1 whose value is not a multiple of the window size still stores the value, but the window turns off.
- R5: A write to field 2 sets the window's live flag from write bit 0. The flag can be set only while the stored start address is a multiple of the size. Field 2 reads the flag in bit 0.
- R6: With bus_en and bus_req high, an address inside a live window raises hit. hit_idx then gives the window number and hit_off gives the address minus the window start.
- R7: When more than one live window contains the address, the lowest-numbered window is reported.
- R8: With bus_en low, hit and bus_ack stay low whatever the window flags are.
- R9: bus_ack is high in the cycle after a request that hit, and low after a request that missed.
- R10: Field 3 (cfg_addr[1:0]=3) is reserved and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Slot bus enable; decoding is live only when high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | IDX_W+2 | {window index, field[1:0]} |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data (combinational) |
| bus_req | input | 1 | Bus request valid |
| bus_addr | input | ADDR_W | Bus request address |
| hit | output | 1 | Request falls in a live window |
| hit_idx | output | IDX_W | Winning window number |
| hit_off | output | ADDR_W | Byte offset into the winning window |
| bus_ack | output | 1 | Acknowledge, one cycle after a hit |

## Verification
The bench builds the block with its default parameters. These are four windows with 32-bit addresses and sizes of 32 bytes, 64 KiB, 256 bytes and 4 KiB. Because the sizes differ, a 32-byte window can be placed inside a 256-byte one, so both overlap priority and first-to-last-byte boundaries can be tested. The 4 KiB window can be given a start address that is not a multiple of its size, which tests refusal and re-enabling. Lookups are also made with the slot enable low while all windows are live.

// File: rtl/periph_window_decoder.sv
module periph_window_decoder #(
  parameter int ADDR_W = 32,
  parameter int NUM_ENT = 4,
  parameter logic [23:0] SZ_LOG2 = {6'd12, 6'd8, 6'd16, 6'd5},
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              cfg_wr,
  input  logic [IDX_W+1:0]  cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [ADDR_W-1:0] hit_off,
  output logic              bus_ack
);

  localparam logic [1:0] F_SIZE = 2'd0;
  localparam logic [1:0] F_BASE = 2'd1;
  localparam logic [1:0] F_CTRL = 2'd2;

  logic [IDX_W-1:0]  cfg_idx;
  logic [1:0]        cfg_fld;
  logic [ADDR_W-1:0] base_q [NUM_ENT];
  logic [ADDR_W-1:0] mask   [NUM_ENT];
  logic [NUM_ENT-1:0] valid_q;
  logic [NUM_ENT-1:0] match;
  logic              found;

  assign cfg_idx = cfg_addr[IDX_W+1:2];
  assign cfg_fld = cfg_addr[1:0];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    localparam int LG = int'(SZ_LOG2[6*g +: 6]);
    logic sel;
    assign mask[g] = (ADDR_W'(1) << LG) - ADDR_W'(1);
    assign sel = cfg_wr && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (sel && cfg_fld == F_BASE) begin
        base_q[g]  <= cfg_wdata;
        valid_q[g] <= (cfg_wdata & mask[g]) == '0;
      end else if (sel && cfg_fld == F_CTRL) begin
        valid_q[g] <= cfg_wdata[0] && ((base_q[g] & mask[g]) == '0);
      end
    end

    assign match[g] = valid_q[g] && ((bus_addr & ~mask[g]) == base_q[g]);
  end

  always_comb begin
    found   = 1'b0;
    hit_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        found   = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign hit     = bus_en && bus_req && found;
  assign hit_off = hit ? (bus_addr & mask[hit_idx]) : '0;

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (cfg_idx == IDX_W'(i)) begin
        case (cfg_fld)
          F_SIZE:  cfg_rdata = mask[i] + ADDR_W'(1);
          F_BASE:  cfg_rdata = base_q[i];
          F_CTRL:  cfg_rdata = ADDR_W'(valid_q[i]);
          default: cfg_rdata = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_ack <= 1'b0;
    else        bus_ack <= hit;
  end

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> valid_q[hit_idx]); // R6

  AST_OFF_FROM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (bus_addr - hit_off) == base_q[hit_idx]); // R6

  AST_MISALIGN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_fld == F_BASE && ((cfg_wdata & mask[cfg_idx]) != '0))
      |=> !valid_q[$past(cfg_idx)]); // R4

  AST_ACK_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(hit)); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> !bus_ack); // R8

endmodule

// File: tb/periph_window_decoder_tb_top.sv
module periph_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_req = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        hit;
  logic [1:0]  hit_idx;
  logic [31:0] hit_off;
  logic        bus_ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  periph_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_req(bus_req), .bus_addr(bus_addr), .hit(hit), .hit_idx(hit_idx),
    .hit_off(hit_off), .bus_ack(bus_ack)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        en;
    logic        h;
    logic [1:0]  ix;
    logic [31:0] off;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{32'h1000_0000, 1'b1, 1'b1, 2'd0, 32'h0000_0000},
    '{32'h1000_001F, 1'b1, 1'b1, 2'd0, 32'h0000_001F},
    '{32'h1000_0020, 1'b1, 1'b1, 2'd2, 32'h0000_0020},
    '{32'h1000_00FF, 1'b1, 1'b1, 2'd2, 32'h0000_00FF},
    '{32'h1000_0100, 1'b1, 1'b0, 2'd0, 32'h0000_0000},
    '{32'h2000_ABCD, 1'b1, 1'b1, 2'd1, 32'h0000_ABCD},
    '{32'h2001_0000, 1'b1, 1'b0, 2'd0, 32'h0000_0000},
    '{32'h3000_0100, 1'b1, 1'b0, 2'd0, 32'h0000_0000},
    '{32'h2000_0004, 1'b0, 1'b0, 2'd0, 32'h0000_0000},
    '{32'h0FFF_FFFF, 1'b1, 1'b0, 2'd0, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] idx, input logic [1:0] fld, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = {idx, fld}; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] idx, input logic [1:0] fld, output logic [31:0] d);
    cfg_addr = {idx, fld};
    #1 d = cfg_rdata;
  endtask

  task automatic lookup(input logic [31:0] a, input logic en, input logic eh,
                        input logic [1:0] ei, input logic [31:0] eo, input string req);
    @(negedge clk);
    bus_addr = a; bus_en = en; bus_req = 1'b1;
    #2;
    chk({req, " hit"}, 32'(hit), 32'(eh));
    if (eh) begin
      chk({req, " idx"}, 32'(hit_idx), 32'(ei));
      chk({req, " off"}, hit_off, eo);
    end
    @(negedge clk);
    bus_req = 1'b0;
    chk({req, " ack R9"}, 32'(bus_ack), 32'(eh));
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      cfg_read(2'(i), 2'd2, r); chk("R1 valid", r, 32'h0);
      cfg_read(2'(i), 2'd1, r); chk("R1 base", r, 32'h0);
    end
    #2 chk("R1 ack", 32'(bus_ack), 32'h0);
    rst_n = 1'b1;
    lookup(32'h0000_0000, 1'b1, 1'b0, 2'd0, 32'h0, "R1");

    // R2: sizes
    cfg_read(2'd0, 2'd0, r); chk("R2 size0", r, 32'd32);
    cfg_read(2'd1, 2'd0, r); chk("R2 size1", r, 32'd65536);
    cfg_read(2'd2, 2'd0, r); chk("R2 size2", r, 32'd256);
    cfg_read(2'd3, 2'd0, r); chk("R2 size3", r, 32'd4096);
    cfg_write(2'd0, 2'd0, 32'h0000_1234);
    cfg_read(2'd0, 2'd0, r); chk("R2 size ro", r, 32'd32);
    cfg_read(2'd0, 2'd2, r); chk("R2 no side effect", r, 32'h0);

    // R3 / R4: base writes
    cfg_write(2'd0, 2'd1, 32'h1000_0000);
    cfg_write(2'd1, 2'd1, 32'h2000_0000);
    cfg_write(2'd2, 2'd1, 32'h1000_0000);
    cfg_write(2'd3, 2'd1, 32'h3000_0100);
    cfg_read(2'd1, 2'd1, r); chk("R3 base", r, 32'h2000_0000);
    cfg_read(2'd1, 2'd2, r); chk("R3 valid", r, 32'h1);
    cfg_read(2'd3, 2'd1, r); chk("R4 base kept", r, 32'h3000_0100);
    cfg_read(2'd3, 2'd2, r); chk("R4 valid", r, 32'h0);
    cfg_read(2'd0, 2'd3, r); chk("R10 reserved", r, 32'h0);

    // R6 R7 R8 R9 vector table
    for (int v = 0; v < 10; v++)
      lookup(VECS[v].addr, VECS[v].en, VECS[v].h, VECS[v].ix, VECS[v].off, "R6/R7/R8 vec");

    // R5: control field
    cfg_write(2'd3, 2'd2, 32'h1);
    cfg_read(2'd3, 2'd2, r); chk("R5 misaligned set", r, 32'h0);
    cfg_write(2'd3, 2'd1, 32'h3000_0000);
    cfg_read(2'd3, 2'd2, r); chk("R3 aligned on", r, 32'h1);
    cfg_write(2'd3, 2'd2, 32'h0);
    cfg_read(2'd3, 2'd2, r); chk("R5 clear", r, 32'h0);
    lookup(32'h3000_0010, 1'b1, 1'b0, 2'd0, 32'h0, "R5 cleared miss");
    cfg_write(2'd3, 2'd2, 32'h1);
    lookup(32'h3000_0FFC, 1'b1, 1'b1, 2'd3, 32'h0000_0FFC, "R5 reenabled");
    lookup(32'h3000_0FFC, 1'b0, 1'b0, 2'd0, 32'h0, "R8 disabled");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule